// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a two-wire serial slave such as a small memory device. It runs on a fast system clock and treats the SCL and SDA pins as ordinary data inputs. Each pin passes through a synchronizer and a stable-count glitch filter. The block then watches the filtered pair for bus conditions and clock edges. It tracks each byte on the bus and decides whether the device was addressed. It acknowledges the address and the bytes written to it, and it shifts read bytes back out. Its only output to the pin is an enable that pulls SDA low.

On the other side sits a command sequencer. The front end hands that sequencer received bytes with a strobe. It takes bytes to transmit from a plain input and pulses a take signal when it captures one. It also reports bus start and stop events, the read/write direction of the current access, the acknowledge result of the master, and a running bit count. A busy input stops the block from answering to its own address. While an internal write is still in progress, the master can therefore poll the device and see no acknowledge until that write completes.

Top module: `tw_slave_front`

## Requirements
- R1: When SDA falls while SCL is high, the block treats it as a START in any state: it releases SDA, pulses `start_seen` and begins taking in an address byte. When SDA rises while SCL is high, the block treats it as a STOP in any state: it releases SDA, pulses `stop_seen` and goes idle.
- R2: The first byte after a START is taken MSB first. Its bits 7..4 must equal 1010 and its bits 3..1 must equal `strap_addr`. Bit 0 selects the direction: 1 means read, 0 means write. On a match, `addr_hit` pulses and `rw_read` holds bit 0.
- R3: After a matching address byte, `sda_drive_low` is high for the ninth clock. After a non-matching byte, SDA stays released and every later bit is ignored until the next START.
- R4: In a write, data bits are sampled on the rising SCL edge, MSB first. After the eighth bit, `rx_valid` pulses with the byte on `rx_byte`, and the block acknowledges that byte on the ninth clock. `bit_phase` gives the number of bits clocked into the current byte.
- R5: When `busy` is high as the address byte completes, the block does not acknowledge even a matching address.
- R6: In a read, `tx_byte` is captured and `tx_take` pulses on the falling SCL edge that ends each acknowledge slot. The bits of the captured byte are driven out MSB first, and each one changes only after a falling SCL edge.
- R7: `stop_after_ack` goes high with `stop_seen` only when, in a write, the STOP follows an acknowledge slot with no data bit other than the STOP's own clock. A STOP after a partial byte gives 0.
- R8: On the ninth clock of a read byte, `mack_valid` pulses and `mack_ok` shows whether the master pulled SDA low. A no-acknowledge ends the read: SDA stays released for the rest of the transfer.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks has no effect. With the default of 6 clocks at 50 MHz, this covers pulses up to 100 ns.
- R10: SDA is open-drain. `sda_drive_low` is the only pin output, and it is high only in an acknowledge slot or in a read data bit whose value is 0.
- R11: After reset, `sda_drive_low` and every pulse output are 0 and `bit_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL pin level, asynchronous |
| sda_in | input | 1 | SDA pin level, asynchronous |
| strap_addr | input | STRAP_W | Strap bits compared with address bits 3..1 |
| busy | input | 1 | Refuse to acknowledge own address |
| tx_byte | input | 8 | Next byte to transmit in a read |
| sda_drive_low | output | 1 | Open-drain enable: pull SDA low |
| start_seen | output | 1 | One-clock pulse on START |
| stop_seen | output | 1 | One-clock pulse on STOP |
| stop_after_ack | output | 1 | With `stop_seen`: STOP came on an acknowledge boundary |
| addr_hit | output | 1 | One-clock pulse on own address accepted |
| rw_read | output | 1 | Direction of the current access, 1 = read |
| rx_valid | output | 1 | One-clock pulse, `rx_byte` holds a written byte |
| rx_byte | output | 8 | Last byte received from the master |
| tx_take | output | 1 | One-clock pulse, `tx_byte` has been captured |
| mack_valid | output | 1 | One-clock pulse at the master's acknowledge bit |
| mack_ok | output | 1 | 1 when the master acknowledged |
| bit_phase | output | 4 | Bits clocked into the current byte |

## Verification
A wrong state in the byte engine shows on SDA within one bus bit. It appears either as a missing or extra pull-down in an acknowledge slot or as a pull-down during a bit the master owns. The bench therefore compares the pin enable against its bus model on every system clock in every window where the master drives. A wrong bit count or shift register shows at the next byte boundary, as a wrong `rx_byte` value, a misplaced acknowledge or a wrong read bit. A wrong stop-boundary or busy decision shows on the single pulse it qualifies.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BIT,
      ST_WR_ACK,
      ST_RD_BIT,
      ST_RD_ACK
   } tw_state_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
   } tw_evt_t;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
   parameter int FILT_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level
);
   localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], pin};
   end

   generate
      if (FILT_CYCLES < 0) begin : g_bad
         $error("tw_line_filter: FILT_CYCLES must not be negative");
      end
      if (FILT_CYCLES == 0) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= 1'b1;
            else        level <= sync_q[1];
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= 1'b1;
               run_q <= '0;
            end else if (sync_q[1] != level) begin
               if (run_q == CW'(FILT_CYCLES - 1)) begin
                  level <= sync_q[1];
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
   import tw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output tw_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      evt.rise  = scl_f & ~scl_q;
      evt.fall  = ~scl_f & scl_q;
      evt.start = scl_f & scl_q & sda_q & ~sda_f;
      evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
   end
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
   import tw_pkg::*;
#(
   parameter logic [3:0] TYPE_CODE = 4'b1010,
   parameter int         STRAP_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  tw_evt_t            evt,
   input  logic               sda_f,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               busy,
   input  logic [BYTE_W-1:0]  tx_byte,
   output logic               sda_drive_low,
   output logic               start_seen,
   output logic               stop_seen,
   output logic               stop_after_ack,
   output logic               addr_hit,
   output logic               rw_read,
   output logic               rx_valid,
   output logic [BYTE_W-1:0]  rx_byte,
   output logic               tx_take,
   output logic               mack_valid,
   output logic               mack_ok,
   output logic [CNT_W-1:0]   bit_phase
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   tw_state_e         state_q;
   logic [BYTE_W-1:0] rx_sh_q;
   logic [BYTE_W-1:0] tx_sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ack_edge_q;
   logic              own_addr;

   assign own_addr  = (rx_sh_q[BYTE_W-1:1] == {TYPE_CODE, strap_addr}) && !busy;
   assign bit_phase = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         rx_sh_q        <= '0;
         tx_sh_q        <= '0;
         cnt_q          <= '0;
         ack_edge_q     <= 1'b0;
         sda_drive_low  <= 1'b0;
         start_seen     <= 1'b0;
         stop_seen      <= 1'b0;
         stop_after_ack <= 1'b0;
         addr_hit       <= 1'b0;
         rw_read        <= 1'b0;
         rx_valid       <= 1'b0;
         rx_byte        <= '0;
         tx_take        <= 1'b0;
         mack_valid     <= 1'b0;
         mack_ok        <= 1'b0;
      end else begin
         start_seen     <= 1'b0;
         stop_seen      <= 1'b0;
         stop_after_ack <= 1'b0;
         addr_hit       <= 1'b0;
         rx_valid       <= 1'b0;
         tx_take        <= 1'b0;
         mack_valid     <= 1'b0;
         if (evt.fall) ack_edge_q <= 1'b0;

         if (evt.start) begin
            state_q       <= ST_ADDR;
            cnt_q         <= '0;
            sda_drive_low <= 1'b0;
            start_seen    <= 1'b1;
            ack_edge_q    <= 1'b0;
         end else if (evt.stop) begin
            stop_after_ack <= ack_edge_q && (state_q == ST_WR_BIT) && (cnt_q == CNT_W'(1));
            state_q        <= ST_IDLE;
            cnt_q          <= '0;
            sda_drive_low  <= 1'b0;
            stop_seen      <= 1'b1;
            ack_edge_q     <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WR_BIT: begin
                  if (evt.rise) begin
                     rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_f};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (evt.fall && cnt_q == LAST_BIT) begin
                     if (state_q == ST_WR_BIT) begin
                        rx_byte       <= rx_sh_q;
                        rx_valid      <= 1'b1;
                        sda_drive_low <= 1'b1;
                        state_q       <= ST_WR_ACK;
                     end else if (own_addr) begin
                        sda_drive_low <= 1'b1;
                        addr_hit      <= 1'b1;
                        rw_read       <= rx_sh_q[0];
                        state_q       <= ST_ADDR_ACK;
                     end else begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK, ST_WR_ACK: begin
                  if (evt.fall) begin
                     cnt_q <= '0;
                     if (state_q == ST_ADDR_ACK && rw_read) begin
                        tx_sh_q       <= tx_byte;
                        sda_drive_low <= ~tx_byte[BYTE_W-1];
                        tx_take       <= 1'b1;
                        state_q       <= ST_RD_BIT;
                     end else begin
                        sda_drive_low <= 1'b0;
                        ack_edge_q    <= 1'b1;
                        state_q       <= ST_WR_BIT;
                     end
                  end
               end
               ST_RD_BIT: begin
                  if (evt.rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (evt.fall) begin
                     if (cnt_q == LAST_BIT) begin
                        sda_drive_low <= 1'b0;
                        state_q       <= ST_RD_ACK;
                     end else begin
                        sda_drive_low <= ~tx_sh_q[BYTE_W-2];
                        tx_sh_q       <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt.rise) begin
                     mack_valid <= 1'b1;
                     mack_ok    <= ~sda_f;
                     if (sda_f) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                     end
                  end else if (evt.fall) begin
                     cnt_q         <= '0;
                     tx_sh_q       <= tx_byte;
                     sda_drive_low <= ~tx_byte[BYTE_W-1];
                     tx_take       <= 1'b1;
                     state_q       <= ST_RD_BIT;
                  end
               end
               default: begin
                  sda_drive_low <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/tw_slave_front.sv
module tw_slave_front
   import tw_pkg::*;
#(
   parameter int         FILT_CYCLES = 6,
   parameter logic [3:0] TYPE_CODE   = 4'b1010,
   parameter int         STRAP_W     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               busy,
   input  logic [7:0]         tx_byte,
   output logic               sda_drive_low,
   output logic               start_seen,
   output logic               stop_seen,
   output logic               stop_after_ack,
   output logic               addr_hit,
   output logic               rw_read,
   output logic               rx_valid,
   output logic [7:0]         rx_byte,
   output logic               tx_take,
   output logic               mack_valid,
   output logic               mack_ok,
   output logic [3:0]         bit_phase
);
   localparam int ADDR_W = 4 + STRAP_W;

   generate
      if (ADDR_W != 7) begin : g_bad_addr
         $error("tw_slave_front: type code plus strap bits must form 7 address bits");
      end
      if (BYTE_W != 8 || CNT_W != 4) begin : g_bad_pkg
         $error("tw_slave_front: package widths do not match the port widths");
      end
   endgenerate

   logic    scl_f, sda_f;
   tw_evt_t evt;

   tw_line_filter #(.FILT_CYCLES(FILT_CYCLES)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin(scl_in), .level(scl_f));

   tw_line_filter #(.FILT_CYCLES(FILT_CYCLES)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin(sda_in), .level(sda_f));

   tw_cond_detect i_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .evt(evt));

   tw_byte_engine #(.TYPE_CODE(TYPE_CODE), .STRAP_W(STRAP_W)) i_engine (
      .clk(clk), .rst_n(rst_n), .evt(evt), .sda_f(sda_f),
      .strap_addr(strap_addr), .busy(busy), .tx_byte(tx_byte),
      .sda_drive_low(sda_drive_low), .start_seen(start_seen),
      .stop_seen(stop_seen), .stop_after_ack(stop_after_ack),
      .addr_hit(addr_hit), .rw_read(rw_read), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_take(tx_take), .mack_valid(mack_valid),
      .mack_ok(mack_ok), .bit_phase(bit_phase));
endmodule

// File: rtl/tw_slave_front_chk.sv
module tw_slave_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       sda_drive_low,
   input logic       start_seen,
   input logic       stop_seen,
   input logic       stop_after_ack,
   input logic       addr_hit,
   input logic       rx_valid,
   input logic       mack_valid,
   input logic [3:0] bit_phase
);
   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |-> !sda_drive_low); // R1
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |-> !sda_drive_low && bit_phase == 4'd0); // R10
   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_seen, stop_seen, rx_valid, mack_valid})); // R1
   AST_HIT_DRIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |-> sda_drive_low); // R3
   AST_HIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |-> !$past(busy)); // R5
   AST_RX_DRIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> sda_drive_low && bit_phase == 4'd8); // R4
   AST_FLAG_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_after_ack |-> stop_seen); // R7
endmodule

bind tw_slave_front tw_slave_front_chk i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sda_drive_low(sda_drive_low),
   .start_seen(start_seen), .stop_seen(stop_seen),
   .stop_after_ack(stop_after_ack), .addr_hit(addr_hit),
   .rx_valid(rx_valid), .mack_valid(mack_valid), .bit_phase(bit_phase));

// File: tb/test_tw_slave_front.sv
module test_tw_slave_front;
   localparam int H = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       busy = 1'b0;
   logic [7:0] tx_byte;
   logic       sda_drive_low, start_seen, stop_seen, stop_after_ack;
   logic       addr_hit, rw_read, rx_valid, tx_take, mack_valid, mack_ok;
   logic [7:0] rx_byte;
   logic [3:0] bit_phase;
   logic       bus;

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_stop = 0, n_hit = 0, n_take = 0, n_mack = 0;
   logic last_flag = 1'b0, last_mack = 1'b0;
   logic [7:0] rxq[$];
   logic [7:0] rd_data[4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
   int  tx_idx = 0;
   logic chk_rel = 1'b0;

   always #10 clk = ~clk;

   assign bus     = sda_m & ~sda_drive_low;
   assign tx_byte = rd_data[tx_idx];

   tw_slave_front i_tw_slave_front (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus),
      .strap_addr(strap), .busy(busy), .tx_byte(tx_byte),
      .sda_drive_low(sda_drive_low), .start_seen(start_seen),
      .stop_seen(stop_seen), .stop_after_ack(stop_after_ack),
      .addr_hit(addr_hit), .rw_read(rw_read), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_take(tx_take), .mack_valid(mack_valid),
      .mack_ok(mack_ok), .bit_phase(bit_phase));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus model observed every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (start_seen) n_start++;
         if (stop_seen) begin n_stop++; last_flag = stop_after_ack; end
         if (addr_hit) n_hit++;
         if (rx_valid) rxq.push_back(rx_byte);
         if (tx_take) begin n_take++; tx_idx = (tx_idx + 1) % 4; end
         if (mack_valid) begin n_mack++; last_mack = mack_ok; end
         if (chk_rel) check("R10 pin enable in master-owned bit", {31'd0, sda_drive_low}, 32'd0);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mbit(input logic b, input logic rel, output logic r);
      idle(12);
      chk_rel = rel;
      sda_m = b;
      idle(H);
      scl_m = 1'b1;
      idle(H);
      r = bus;
      scl_m = 1'b0;
      chk_rel = 1'b0;
   endtask

   task automatic bus_start();
      idle(12);
      sda_m = 1'b1;
      idle(H);
      scl_m = 1'b1;
      idle(H);
      sda_m = 1'b0;
      idle(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      idle(12);
      sda_m = 1'b0;
      idle(H);
      scl_m = 1'b1;
      idle(H);
      sda_m = 1'b1;
      idle(H);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ackbit);
      logic r;
      for (int i = 7; i >= 0; i--) mbit(d[i], 1'b1, r);
      mbit(1'b1, 1'b0, ackbit);
   endtask

   task automatic recv_byte(input logic do_ack, output logic [7:0] d);
      logic r;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         mbit(1'b1, 1'b0, r);
         d = {d[6:0], r};
      end
      mbit(~do_ack, 1'b0, r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the end of the run");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      int s0, rx0;
      idle(5);
      rst_n = 1'b1;
      idle(5);
      // R11 reset state
      check("R11 drive after reset", {31'd0, sda_drive_low}, 32'd0);
      check("R11 bit_phase after reset", {28'd0, bit_phase}, 32'd0);
      check("R11 no pulses after reset", n_start + n_stop + n_hit + rxq.size(), 0);

      // write of two bytes ending on an acknowledge boundary
      bus_start();
      check("R1 start pulse", n_start, 1);
      send_byte(8'hAA, a);
      check("R3 address ack", {31'd0, a}, 32'd0);
      check("R2 address hit", n_hit, 1);
      check("R2 direction write", {31'd0, rw_read}, 32'd0);
      send_byte(8'h12, a);
      check("R4 data ack 1", {31'd0, a}, 32'd0);
      send_byte(8'hC5, a);
      check("R4 data ack 2", {31'd0, a}, 32'd0);
      check("R4 byte count", rxq.size(), 2);
      if (rxq.size() == 2) begin
         check("R4 first byte", {24'd0, rxq[0]}, 32'h12);
         check("R4 second byte", {24'd0, rxq[1]}, 32'hC5);
      end
      bus_stop();
      check("R1 stop pulse", n_stop, 1);
      check("R7 stop on boundary", {31'd0, last_flag}, 32'd1);

      // stop after a partial byte
      bus_start();
      send_byte(8'hAA, a);
      mbit(1'b1, 1'b1, a);
      mbit(1'b0, 1'b1, a);
      mbit(1'b1, 1'b1, a);
      idle(4);
      check("R4 bit_phase mid byte", {28'd0, bit_phase}, 32'd3);
      bus_stop();
      check("R7 stop mid byte", {31'd0, last_flag}, 32'd0);
      check("R4 no byte from partial", rxq.size(), 2);

      // strap mismatch then ignored byte
      bus_start();
      send_byte(8'hA8, a);
      check("R3 strap mismatch no ack", {31'd0, a}, 32'd1);
      send_byte(8'h00, a);
      check("R3 ignored after mismatch ack", {31'd0, a}, 32'd1);
      check("R3 ignored after mismatch rx", rxq.size(), 2);
      bus_stop();

      // wrong type code
      bus_start();
      send_byte(8'hBA, a);
      check("R2 type code mismatch", {31'd0, a}, 32'd1);
      bus_stop();
      check("R2 hits so far", n_hit, 2);

      // busy polling
      busy = 1'b1;
      bus_start();
      send_byte(8'hAA, a);
      check("R5 busy refuses", {31'd0, a}, 32'd1);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte(8'hAA, a);
      check("R5 idle accepts", {31'd0, a}, 32'd0);
      bus_stop();

      // read of two bytes, ack then no-ack
      bus_start();
      send_byte(8'hAB, a);
      check("R3 read address ack", {31'd0, a}, 32'd0);
      check("R2 direction read", {31'd0, rw_read}, 32'd1);
      recv_byte(1'b1, d);
      check("R6 first read byte", {24'd0, d}, 32'hA5);
      check("R8 master ack seen", {31'd0, last_mack}, 32'd1);
      recv_byte(1'b0, d);
      check("R6 second read byte", {24'd0, d}, 32'h3C);
      check("R6 take count", n_take, 2);
      check("R8 master no-ack seen", {31'd0, last_mack}, 32'd0);
      check("R8 ack result count", n_mack, 2);
      for (int i = 0; i < 9; i++) begin
         mbit(1'b1, 1'b1, a);
         check("R8 released after no-ack", {31'd0, a}, 32'd1);
      end
      check("R8 no further take", n_take, 2);
      bus_stop();
      check("R7 stop after read", {31'd0, last_flag}, 32'd0);

      // repeated start in the middle of a write byte
      bus_start();
      send_byte(8'hAA, a);
      mbit(1'b0, 1'b1, a);
      mbit(1'b1, 1'b1, a);
      s0 = n_start;
      bus_start();
      check("R1 restart mid byte", n_start, s0 + 1);
      send_byte(8'hAA, a);
      check("R1 address after restart", {31'd0, a}, 32'd0);
      send_byte(8'h77, a);
      rx0 = rxq.size();
      check("R4 byte after restart", {24'd0, rxq[rx0-1]}, 32'h77);
      bus_stop();

      // short SDA pulse while idle
      idle(20);
      s0 = n_start;
      sda_m = 1'b0;
      idle(3);
      sda_m = 1'b1;
      idle(40);
      check("R9 short pulse ignored", n_start, s0);
      check("R9 no stop from pulse", n_stop, 8);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule